// File: doc/BRIEF.md
# Late-Resolve Instruction Fetch Controller

This block drives the front end of a five-stage in-order pipeline in which a branch is resolved only once decode has finished with it. It holds the fetch program counter and reads a synchronous-read instruction array. Each cycle it hands one instruction to decode, together with that instruction's address and a valid flag. Decode answers in the same cycle with three signals: whether the instruction it holds is a branch, whether that branch is taken, and the target. The controller uses these to choose the next fetch address.

A mode input selects how the cycle lost to late resolution is handled. In bubble mode the controller replaces the slot after every branch with an invalid all-zero word, which changes no state, and fetches the target or the fall-through address right after. In delay-slot mode the word after the branch always reaches decode as a valid instruction, and the redirect takes effect on the fetch after that word. A counter records every inserted bubble so that the cycle cost of each mode can be measured. A write port fills the instruction array.

Top module: `fetch_ctrl`

## Requirements
- R1: While `rst` is high, and at the first sample after it, `fetch_pc` equals `RESET_VEC`, `id_valid` is 0, `id_instr` is all zeros and `bubble_count` is 0.
- R2: When no valid branch is in decode, `fetch_pc` grows by 4 each cycle. One cycle after an address is fetched, decode holds the array word at byte address A, that is word index (A>>2) mod `IMEM_DEPTH`, with `id_pc` = A and `id_valid` = 1.
- R3: With `delay_mode` = 0, the decode slot in the cycle after a valid branch is a bubble: `id_valid` = 0 and `id_instr` = 0, for both taken and not-taken branches.
- R4: With `delay_mode` = 0, the next valid instruction after the bubble comes from `id_target` when the branch was taken, and from the branch address + 4 when it was not.
- R5: With `delay_mode` = 1, the instruction at the branch address + 4 follows the branch into decode as a valid instruction, whether or not the branch is taken.
- R6: With `delay_mode` = 1, the instruction after the delay slot comes from `id_target` when the branch was taken, and from the branch address + 8 when it was not. No bubble is inserted.
- R7: A word written through `imem_we`/`imem_waddr`/`imem_wdata` at a word index is returned by later fetches of the matching address.
- R8: `bubble_count` increases by exactly one for each inserted bubble and stays unchanged otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| delay_mode | input | 1 | 0 = bubble after branch, 1 = delay slot |
| imem_we | input | 1 | Instruction array write enable |
| imem_waddr | input | AW | Word index to write |
| imem_wdata | input | INSTR_W | Word to write |
| id_branch | input | 1 | Decode reports that its instruction is a branch |
| id_taken | input | 1 | Decode reports that the branch is taken |
| id_target | input | PC_W | Branch target byte address from decode |
| fetch_pc | output | PC_W | Address being fetched this cycle |
| id_valid | output | 1 | Instruction in decode is real (0 = bubble) |
| id_pc | output | PC_W | Address of the instruction in decode |
| id_instr | output | INSTR_W | Instruction word in decode |
| bubble_count | output | CNT_W | Count of inserted bubbles |

## Verification
The bench builds the block with `IMEM_DEPTH` = 64 and `RESET_VEC` = 0x40, so a program starts at word 16 and the whole array can be rewritten between runs. The same program is run in both modes. It contains taken and not-taken branches and a taken branch whose target is itself a branch, which exposes the difference between the modes in bubble placement, redirect timing and bubble count. A second program places two not-taken branches back to back in bubble mode, which checks that a refetched fall-through address is not skipped.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  typedef enum logic {
    BR_BUBBLE = 1'b0,
    BR_DELAY  = 1'b1
  } br_mode_e;

  localparam int unsigned WORD_BYTES = 4;
endpackage

// File: rtl/fetch_imem.sv
module fetch_imem #(
  parameter int unsigned DEPTH   = 256,
  parameter int unsigned INSTR_W = 32,
  parameter int unsigned PC_W    = 32,
  localparam int unsigned AW     = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [AW-1:0]      waddr,
  input  logic [INSTR_W-1:0] wdata,
  input  logic [PC_W-1:0]    rd_pc,
  input  logic               kill,
  output logic [INSTR_W-1:0] rdata
);
  logic [INSTR_W-1:0] mem [DEPTH];
  logic [AW-1:0]      ridx;

  // Byte address to word index; upper bits wrap.
  assign ridx = AW'(rd_pc >> 2);

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Output register with synchronous clear: a bubble reads as zero.
  always_ff @(posedge clk) begin
    if (rst || kill) rdata <= '0;
    else             rdata <= mem[ridx];
  end
endmodule

// File: rtl/fetch_redirect.sv
module fetch_redirect
  import fetch_pkg::*;
#(
  parameter int unsigned PC_W = 32
) (
  input  br_mode_e        mode,
  input  logic            id_valid,
  input  logic            id_branch,
  input  logic            id_taken,
  input  logic [PC_W-1:0] id_target,
  input  logic [PC_W-1:0] fetch_pc,
  output logic [PC_W-1:0] next_pc,
  output logic            squash
);
  logic            live_br;
  logic [PC_W-1:0] seq_pc;

  assign live_br = id_valid & id_branch;
  assign seq_pc  = fetch_pc + PC_W'(WORD_BYTES);

  always_comb begin
    next_pc = seq_pc;
    squash  = 1'b0;
    if (live_br) begin
      if (mode == BR_BUBBLE) begin
        // The word fetched beside the branch is dropped; refetch it if not taken.
        squash  = 1'b1;
        next_pc = id_taken ? id_target : fetch_pc;
      end else begin
        next_pc = id_taken ? id_target : seq_pc;
      end
    end
  end
endmodule

// File: rtl/fetch_bubble_ctr.sv
module fetch_bubble_ctr #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (inc) count <= count + 1'b1;
  end
endmodule

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
  import fetch_pkg::*;
#(
  parameter int unsigned IMEM_DEPTH = 256,
  parameter int unsigned INSTR_W    = 32,
  parameter int unsigned PC_W       = 32,
  parameter int unsigned CNT_W      = 16,
  parameter logic [31:0] RESET_VEC  = 32'h0000_0000,
  localparam int unsigned AW        = $clog2(IMEM_DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               delay_mode,
  input  logic               imem_we,
  input  logic [AW-1:0]      imem_waddr,
  input  logic [INSTR_W-1:0] imem_wdata,
  input  logic               id_branch,
  input  logic               id_taken,
  input  logic [PC_W-1:0]    id_target,
  output logic [PC_W-1:0]    fetch_pc,
  output logic               id_valid,
  output logic [PC_W-1:0]    id_pc,
  output logic [INSTR_W-1:0] id_instr,
  output logic [CNT_W-1:0]   bubble_count
);
  localparam logic [PC_W-1:0] RST_PC = PC_W'(RESET_VEC);

  br_mode_e        mode;
  logic [PC_W-1:0] next_pc;
  logic            squash;

  assign mode = br_mode_e'(delay_mode);

  fetch_redirect #(.PC_W(PC_W)) u_redirect (
    .mode      (mode),
    .id_valid  (id_valid),
    .id_branch (id_branch),
    .id_taken  (id_taken),
    .id_target (id_target),
    .fetch_pc  (fetch_pc),
    .next_pc   (next_pc),
    .squash    (squash)
  );

  always_ff @(posedge clk) begin
    if (rst) fetch_pc <= RST_PC;
    else     fetch_pc <= next_pc;
  end

  // Decode-stage sideband registers, aligned with the array output register.
  always_ff @(posedge clk) begin
    if (rst || squash) begin
      id_valid <= 1'b0;
      id_pc    <= '0;
    end else begin
      id_valid <= 1'b1;
      id_pc    <= fetch_pc;
    end
  end

  fetch_imem #(
    .DEPTH   (IMEM_DEPTH),
    .INSTR_W (INSTR_W),
    .PC_W    (PC_W)
  ) u_imem (
    .clk   (clk),
    .rst   (rst),
    .we    (imem_we),
    .waddr (imem_waddr),
    .wdata (imem_wdata),
    .rd_pc (fetch_pc),
    .kill  (squash),
    .rdata (id_instr)
  );

  fetch_bubble_ctr #(.CNT_W(CNT_W)) u_bubbles (
    .clk   (clk),
    .rst   (rst),
    .inc   (squash),
    .count (bubble_count)
  );
endmodule

// File: rtl/fetch_ctrl_chk.sv
module fetch_ctrl_chk #(
  parameter int unsigned INSTR_W   = 32,
  parameter int unsigned PC_W      = 32,
  parameter int unsigned CNT_W     = 16,
  parameter logic [31:0] RESET_VEC = 32'h0000_0000
) (
  input logic               clk,
  input logic               rst,
  input logic               delay_mode,
  input logic               id_branch,
  input logic               id_taken,
  input logic [PC_W-1:0]    id_target,
  input logic [PC_W-1:0]    fetch_pc,
  input logic               id_valid,
  input logic [PC_W-1:0]    id_pc,
  input logic [INSTR_W-1:0] id_instr,
  input logic [CNT_W-1:0]   bubble_count
);
  logic br_now;
  assign br_now = id_valid & id_branch;

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (fetch_pc == PC_W'(RESET_VEC)) && !id_valid && (bubble_count == '0));

  p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
    !br_now |=> fetch_pc == $past(fetch_pc) + PC_W'(4));

  p_bubble_slot_r3: assert property (@(posedge clk) disable iff (rst)
    (br_now && !delay_mode) |=> !id_valid);

  p_bubble_zero_r3: assert property (@(posedge clk) disable iff (rst)
    !id_valid |-> id_instr == '0);

  p_taken_target_r4: assert property (@(posedge clk) disable iff (rst)
    (br_now && id_taken) |=> fetch_pc == $past(id_target));

  p_fallthru_r6: assert property (@(posedge clk) disable iff (rst)
    (br_now && !id_taken) |=>
      fetch_pc == $past(id_pc) + ($past(delay_mode) ? PC_W'(8) : PC_W'(4)));

  p_delay_slot_r5: assert property (@(posedge clk) disable iff (rst)
    (br_now && delay_mode) |=> id_valid && (id_pc == $past(id_pc) + PC_W'(4)));

  p_count_step_r8: assert property (@(posedge clk) disable iff (rst)
    (br_now && !delay_mode) |=> bubble_count == CNT_W'($past(bubble_count) + 1'b1));

  p_count_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !(br_now && !delay_mode) |=> $stable(bubble_count));
endmodule

bind fetch_ctrl fetch_ctrl_chk #(
  .INSTR_W   (INSTR_W),
  .PC_W      (PC_W),
  .CNT_W     (CNT_W),
  .RESET_VEC (RESET_VEC)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .delay_mode   (delay_mode),
  .id_branch    (id_branch),
  .id_taken     (id_taken),
  .id_target    (id_target),
  .fetch_pc     (fetch_pc),
  .id_valid     (id_valid),
  .id_pc        (id_pc),
  .id_instr     (id_instr),
  .bubble_count (bubble_count)
);

// File: tb/tb_fetch_ctrl.sv
`timescale 1ns/1ps
module tb_fetch_ctrl;
  localparam int unsigned DEPTH = 64;
  localparam int unsigned AW    = $clog2(DEPTH);
  localparam int unsigned PCW   = 32;
  localparam int unsigned CW    = 16;
  localparam logic [31:0] RV    = 32'h0000_0040;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          delay_mode = 1'b0;
  logic          imem_we = 1'b0;
  logic [AW-1:0] imem_waddr = '0;
  logic [31:0]   imem_wdata = '0;
  logic          id_branch, id_taken;
  logic [31:0]   id_target, fetch_pc, id_pc, id_instr;
  logic          id_valid;
  logic [CW-1:0] bubble_count;

  always #2 clk = ~clk;

  // Bench-side decode: opcode 6'h04 in [31:26] is a branch, [25] = taken,
  // [15:0] = target word address.
  assign id_branch = id_valid && (id_instr[31:26] == 6'h04);
  assign id_taken  = id_instr[25];
  assign id_target = {14'b0, id_instr[15:0], 2'b00};

  fetch_ctrl #(
    .IMEM_DEPTH (DEPTH), .INSTR_W (32), .PC_W (PCW), .CNT_W (CW), .RESET_VEC (RV)
  ) dut (
    .clk (clk), .rst (rst), .delay_mode (delay_mode),
    .imem_we (imem_we), .imem_waddr (imem_waddr), .imem_wdata (imem_wdata),
    .id_branch (id_branch), .id_taken (id_taken), .id_target (id_target),
    .fetch_pc (fetch_pc), .id_valid (id_valid), .id_pc (id_pc),
    .id_instr (id_instr), .bubble_count (bubble_count)
  );

  typedef struct {
    logic        v;
    logic [31:0] pc;
    logic [31:0] w;
    string       req;
  } item_t;

  item_t       q[$];
  logic [31:0] prog [DEPTH];
  int          n_chk = 0;
  int          n_fail = 0;
  logic        mon_en = 1'b0;
  int          exp_bub;

  function automatic logic [31:0] br_word(bit tk, int tgt_word);
    return {6'h04, tk, 9'b0, 16'(tgt_word)};
  endfunction

  function automatic logic [31:0] at(logic [31:0] pc);
    return prog[(pc >> 2) % DEPTH];
  endfunction

  function automatic bit is_br(logic [31:0] w);
    return w[31:26] == 6'h04;
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Monitor: pop and compare one expected decode slot per cycle.
  always @(negedge clk) begin
    if (mon_en && q.size() > 0) begin
      item_t e;
      e = q.pop_front();
      if (e.v)
        check(id_valid && id_pc == e.pc && id_instr == e.w, e.req, "slot pc/instr",
              id_valid ? id_instr : 32'hDEAD_0000, e.w);
      else
        check(!id_valid && id_instr == 32'h0, e.req, "bubble", id_instr, 32'h0);
    end
  end

  task automatic fill_plain();
    for (int i = 0; i < DEPTH; i++) prog[i] = 32'hA000_0000 | 32'(i);
  endtask

  // Expected stream from the requirements.
  task automatic build_expect(bit dm, int n);
    logic [31:0] pc;
    logic [31:0] w;
    string       nreq;
    pc = RV;
    nreq = "R7";
    exp_bub = 0;
    while (q.size() < n) begin
      w = at(pc);
      q.push_back('{1'b1, pc, w, nreq});
      nreq = "R2";
      if (is_br(w)) begin
        if (!dm) begin
          q.push_back('{1'b0, 32'h0, 32'h0, "R3"});
          exp_bub++;
          pc = w[25] ? {14'b0, w[15:0], 2'b00} : pc + 4;
          nreq = "R4";
        end else begin
          q.push_back('{1'b1, pc + 4, at(pc + 4), "R5"});
          pc = w[25] ? {14'b0, w[15:0], 2'b00} : pc + 8;
          nreq = "R6";
        end
      end else begin
        pc = pc + 4;
      end
    end
  endtask

  task automatic run_test(bit dm, int n);
    rst = 1'b1;
    delay_mode = dm;
    @(negedge clk);
    // R7: load the array through the write port while held in reset.
    for (int i = 0; i < DEPTH; i++) begin
      imem_we = 1'b1; imem_waddr = AW'(i); imem_wdata = prog[i];
      @(negedge clk);
    end
    imem_we = 1'b0;
    @(negedge clk);
    check(fetch_pc == RV, "R1", "reset pc", fetch_pc, RV);
    check(!id_valid && id_instr == 0, "R1", "reset decode", id_instr, 32'h0);
    check(bubble_count == 0, "R1", "reset count", 32'(bubble_count), 32'h0);
    build_expect(dm, n);
    rst = 1'b0;
    @(posedge clk);
    mon_en = 1'b1;
    wait (q.size() == 0);
    mon_en = 1'b0;
    check(32'(bubble_count) == 32'(exp_bub), "R8", "bubble count",
          32'(bubble_count), 32'(exp_bub));
    @(negedge clk);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // Program A: taken, taken-to-branch, not-taken, loop back.
    fill_plain();
    prog[18] = br_word(1'b1, 30);
    prog[30] = br_word(1'b1, 20);
    prog[22] = br_word(1'b0, 40);
    prog[25] = br_word(1'b1, 17);
    run_test(1'b0, 24);   // R3 R4 R8
    run_test(1'b1, 24);   // R5 R6 R8
    // Program B: back-to-back not-taken branches, bubble mode only.
    fill_plain();
    prog[17] = br_word(1'b0, 50);
    prog[18] = br_word(1'b0, 50);
    prog[20] = br_word(1'b1, 16);
    run_test(1'b0, 16);   // R3 R4
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule